// File: doc/BRIEF.md
# Masked Multi-Slot I2C Target Address Matcher

This block decides whether an address byte just shifted in from an I2C bus is meant for this device. It checks the 7-bit address against four programmable own-address slots. Each slot has its own per-bit don't-care mask and its own general-call enable. The serial front end presents the captured byte and pulses a valid strobe. One clock later the block reports whether any slot accepted the byte, which slot won, whether the byte was a general call, and the transfer direction taken from the R/W bit.

Each slot also keeps a sticky hit flag that software clears by writing 1. This lets firmware see every slot that answered, not just the reported winner. While the controller runs as a bus master, the block ignores the strobe entirely. The shift register, ACK driving and register bus live elsewhere.

Top module: `i2c_addr_matcher`

## Requirements
- R1: Slot i is configured by byte i of `slot_cfg_i` (bits [8i+7:8i+1] hold the 7-bit address, bit 8i holds the general-call enable). A non-zero received address (`rx_byte_i[7:1]`) matches a slot when every unmasked bit equals the slot address. Bit 0 of the received byte never takes part in the compare.
- R2: Bit 8i+k (k = 1..7) of `slot_mask_i` set to 1 makes received address bit k a don't-care for slot i. A 0 in that bit demands equality.
- R3: A slot whose address field is 0 never produces an address match, whatever its mask holds.
- R4: A received address of 0 is a general call. It is accepted only by slots whose general-call enable is 1, and masks and addresses play no part in it. An accepted general call raises `gen_call_o` together with `match_o`.
- R5: When several slots accept the same byte, `match_idx_o` reports the lowest-numbered one, and every accepting slot sets its own status flag.
- R6: Results appear on the clock edge after the edge that samples `rx_valid_i` high. `match_o` is high only in the cycle that follows an accepted strobe. Without a strobe it stays low.
- R7: `rw_o` takes `rx_byte_i[0]` on each accepted byte. It holds its value across rejected bytes and idle cycles.
- R8: `match_flags_o[i]` stays set until a cycle with `flag_clr_i[i]` = 1. If a new hit and a clear land in the same cycle, the flag ends up set.
- R9: While `is_master_i` is 1, a strobe produces no match, sets no flag and leaves `rw_o` unchanged.
- R10: After reset, `match_o`, `match_idx_o`, `gen_call_o`, `rw_o` and `match_flags_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_cfg_i | input | 32 | Per-slot byte: address [7:1], general-call enable [0] |
| slot_mask_i | input | 32 | Per-slot byte: don't-care mask [7:1], bit 0 unused |
| is_master_i | input | 1 | Controller is acting as bus master |
| rx_byte_i | input | 8 | Captured address byte, R/W in bit 0 |
| rx_valid_i | input | 1 | One-cycle strobe: rx_byte_i holds a complete address byte |
| flag_clr_i | input | 4 | Write-1-to-clear pulses for the slot flags |
| match_o | output | 1 | Byte accepted by at least one slot |
| match_idx_o | output | 2 | Lowest accepting slot of the last accepted byte |
| gen_call_o | output | 1 | Accepted byte was a general call |
| rw_o | output | 1 | Direction latched from the last accepted byte |
| match_flags_o | output | 4 | Sticky per-slot hit flags |

## Verification
The hardest case to reach is a single byte that several slots accept at once through different routes. One example is a slot whose mask makes every bit don't-care, set against a slot with an exact address, or against general-call enables on both ends of the slot range. Table vectors therefore program overlapping slots on purpose, so that both the priority pick and the per-slot flags are exercised. A separate directed sequence lands a hit and a clear in the same cycle to probe the set-over-clear rule.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned SLOTS_DEF  = 4;
  localparam int unsigned ADDR_W_DEF = 7;
endpackage

// File: rtl/i2c_am_slot_cmp.sv
// One slot: masked address compare plus general-call acceptance.
module i2c_am_slot_cmp #(
  parameter int unsigned AW = 7
) (
  input  logic [AW:0]   cfg_i,   // [AW:1] address, [0] gc enable
  input  logic [AW:0]   mask_i,  // [AW:1] don't-care bits
  input  logic [AW-1:0] rx_addr_i,
  output logic          addr_hit_o,
  output logic          gc_hit_o
);
  logic [AW-1:0] slot_addr;
  logic [AW-1:0] care;
  logic          rx_is_gc;

  assign slot_addr = cfg_i[AW:1];
  assign care      = ~mask_i[AW:1];
  assign rx_is_gc  = (rx_addr_i == '0);

  assign addr_hit_o = !rx_is_gc && (slot_addr != '0) &&
                      (((rx_addr_i ^ slot_addr) & care) == '0);
  assign gc_hit_o   = rx_is_gc && cfg_i[0];
endmodule

// File: rtl/i2c_am_prio_pick.sv
// Lowest-index winner among the request bits.
module i2c_am_prio_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/i2c_am_flags.sv
// Sticky hit flags, write-1-to-clear, set wins over clear.
module i2c_am_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | set_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[g] && !clr_i[g]) |=> flags_o[g]);
    p_flag_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flags_o[g]);
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = SLOTS_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  localparam int unsigned BYTE_W   = ADDR_W + 1,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SLOTS*BYTE_W-1:0]   slot_cfg_i,
  input  logic [NUM_SLOTS*BYTE_W-1:0]   slot_mask_i,
  input  logic                          is_master_i,
  input  logic [BYTE_W-1:0]             rx_byte_i,
  input  logic                          rx_valid_i,
  input  logic [NUM_SLOTS-1:0]          flag_clr_i,
  output logic                          match_o,
  output logic [IDX_W-1:0]              match_idx_o,
  output logic                          gen_call_o,
  output logic                          rw_o,
  output logic [NUM_SLOTS-1:0]          match_flags_o
);
  logic [ADDR_W-1:0]    rx_addr;
  logic [NUM_SLOTS-1:0] addr_hit, gc_hit, hit;
  logic                 take, any_hit;
  logic [IDX_W-1:0]     win_idx;

  assign rx_addr = rx_byte_i[BYTE_W-1:1];
  assign take    = rx_valid_i && !is_master_i;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    i2c_am_slot_cmp #(.AW(ADDR_W)) u_cmp (
      .cfg_i      (slot_cfg_i[g*BYTE_W +: BYTE_W]),
      .mask_i     (slot_mask_i[g*BYTE_W +: BYTE_W]),
      .rx_addr_i  (rx_addr),
      .addr_hit_o (addr_hit[g]),
      .gc_hit_o   (gc_hit[g])
    );
    assign hit[g] = addr_hit[g] | gc_hit[g];
  end

  i2c_am_prio_pick #(.N(NUM_SLOTS), .IW(IDX_W)) u_pick (
    .req_i (hit),
    .any_o (any_hit),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o     <= 1'b0;
      match_idx_o <= '0;
      gen_call_o  <= 1'b0;
      rw_o        <= 1'b0;
    end else begin
      match_o    <= take && any_hit;
      gen_call_o <= take && (|gc_hit);
      if (take && any_hit) begin
        match_idx_o <= win_idx;
        rw_o        <= rx_byte_i[0];
      end
    end
  end

  i2c_am_flags #(.N(NUM_SLOTS)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (take ? hit : '0),
    .clr_i   (flag_clr_i),
    .flags_o (match_flags_o)
  );

  p_master_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_master_i |=> !match_o && !gen_call_o);
  p_needs_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !match_o);
  p_gc_has_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_call_o |-> match_o);
  p_rw_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> $stable(rw_o));
  p_winner_flagged_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> match_flags_o[match_idx_o]);
endmodule

// File: tb/i2c_addr_matcher_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0, msk = '0;
  logic        master = 1'b0;
  logic [7:0]  rx = '0;
  logic        vld = 1'b0;
  logic [3:0]  clr = '0;
  logic        m_o, gc_o, rw_o;
  logic [1:0]  idx_o;
  logic [3:0]  fl_o;
  int          n_chk = 0, n_fail = 0;
  logic        exp_rw = 1'b0;

  always #2 clk = ~clk;

  i2c_addr_matcher dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slot_cfg_i(cfg), .slot_mask_i(msk),
    .is_master_i(master), .rx_byte_i(rx), .rx_valid_i(vld),
    .flag_clr_i(clr), .match_o(m_o), .match_idx_o(idx_o),
    .gen_call_o(gc_o), .rw_o(rw_o), .match_flags_o(fl_o)
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] msk;
    logic [7:0]  rx;
    logic        m;
    logic [1:0]  idx;
    logic        gc;
    logic [3:0]  fl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h000000A0, 32'h00000000, 8'hA1, 1'b1, 2'd0, 1'b0, 4'b0001}, // R1 exact
    '{32'h000000A0, 32'h00000000, 8'hA2, 1'b0, 2'd0, 1'b0, 4'b0000}, // R1 miss
    '{32'h00006000, 32'h00000E00, 8'h6A, 1'b1, 2'd1, 1'b0, 4'b0010}, // R2 masked
    '{32'h00006000, 32'h00000E00, 8'h7A, 1'b0, 2'd0, 1'b0, 4'b0000}, // R2 cared bit
    '{32'h00000000, 32'h00FE0000, 8'h24, 1'b0, 2'd0, 1'b0, 4'b0000}, // R3 zero slot
    '{32'h000000A0, 32'h00000000, 8'h00, 1'b0, 2'd0, 1'b0, 4'b0000}, // R4 gc off
    '{32'h00010000, 32'h00000000, 8'h00, 1'b1, 2'd2, 1'b1, 4'b0100}, // R4 gc on
    '{32'h24006020, 32'h0000FE00, 8'h24, 1'b1, 2'd1, 1'b0, 4'b1010}, // R5 multi
    '{32'h010060A1, 32'h0000FE00, 8'h00, 1'b1, 2'd0, 1'b1, 4'b1001}  // R5/R4 gc multi
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive strobe at negedge, sample at next negedge (one register stage).
  task automatic strobe(input logic [7:0] b, input logic [3:0] c);
    @(negedge clk);
    rx = b; vld = 1'b1; clr = c;
    @(negedge clk);
    vld = 1'b0; clr = '0;
  endtask

  task automatic clear_all();
    clr = 4'hF;
    @(negedge clk);
    clr = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 match", {7'd0, m_o}, 8'd0);
    check("R10 idx/gc/rw", {3'd0, idx_o, gc_o, rw_o, 1'b0}, 8'd0);
    check("R10 flags", {4'd0, fl_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cfg = VEC[i].cfg; msk = VEC[i].msk;
      strobe(VEC[i].rx, 4'h0);
      if (VEC[i].m) exp_rw = VEC[i].rx[0];
      check($sformatf("R1/R2/R3 v%0d match", i), {7'd0, m_o}, {7'd0, VEC[i].m});
      if (VEC[i].m) check($sformatf("R5 v%0d idx", i), {6'd0, idx_o}, {6'd0, VEC[i].idx});
      check($sformatf("R4 v%0d gc", i), {7'd0, gc_o}, {7'd0, VEC[i].gc});
      check($sformatf("R5 v%0d flags", i), {4'd0, fl_o}, {4'd0, VEC[i].fl});
      check($sformatf("R7 v%0d rw", i), {7'd0, rw_o}, {7'd0, exp_rw});
      clear_all();
    end

    // R6: pulse lasts one cycle; no strobe, no match
    cfg = 32'h000000A0; msk = '0;
    strobe(8'hA1, 4'h0);
    check("R6 match after strobe", {7'd0, m_o}, 8'd1);
    @(negedge clk);
    check("R6 match drops", {7'd0, m_o}, 8'd0);
    rx = 8'hA0;
    repeat (2) @(negedge clk);
    check("R6 no strobe", {7'd0, m_o}, 8'd0);
    check("R7 rw held idle", {7'd0, rw_o}, 8'd1);

    // R7: rejected byte keeps direction
    strobe(8'hB0, 4'h0);
    check("R7 rw held on miss", {7'd0, rw_o}, 8'd1);

    // R8: sticky, selective clear, set wins over clear
    check("R8 flag still set", {4'd0, fl_o}, 8'h01);
    clr = 4'b0010; @(negedge clk); clr = '0;
    check("R8 other clear no effect", {4'd0, fl_o}, 8'h01);
    clr = 4'b0001; @(negedge clk); clr = '0;
    check("R8 clear", {4'd0, fl_o}, 8'h00);
    strobe(8'hA0, 4'b0001);
    check("R8 set beats clear", {4'd0, fl_o}, 8'h01);
    check("R7 rw write", {7'd0, rw_o}, 8'd0);
    clear_all();

    // R9: master mode ignores strobe
    master = 1'b1;
    strobe(8'hA1, 4'h0);
    check("R9 no match", {7'd0, m_o}, 8'd0);
    check("R9 no flag", {4'd0, fl_o}, 8'd0);
    check("R9 rw kept", {7'd0, rw_o}, 8'd0);
    master = 1'b0;
    strobe(8'hA1, 4'h0);
    check("R9 target again", {7'd0, m_o}, 8'd1);

    finish_run();
  end
endmodule